// File: doc/BRIEF.md
# Time-Slotted Dual-Host Register File

This block is a small register-file memory that two independent hosts share with no busy flags, semaphores or wait states. A free-running four-step sequencer cuts time into repeating slots. Host A owns the first two slots of every round and host B owns the last two, so the two hosts never touch the storage in the same clock cycle. Contention cannot occur, so no arbitration is needed.

Inside its own window a host first commits an optional write, then fetches read data into a registered output. A host that writes and reads one location in the same window therefore sees its new value. A host that only reads sees whatever is already stored. The read output keeps its value until that host's next read slot. Both hosts run on one system clock. The address, write data and write-enable inputs are sampled only at the start of the host's window.

Top module: `tsm_shared_mem`

## Requirements
- R1: Synchronous active-high reset clears every word to zero and drives both read outputs to zero. The slot counter restarts at slot 0.
- R2: The slot counter steps 0,1,2,3 and wraps to 0. Slot 0 is A-write, slot 1 is A-read, slot 2 is B-write and slot 3 is B-read. A read output changes only on the clock edge that ends its own read slot, and never on the edge that ends its write slot.
- R3: A write is committed only on the edge that ends the writer's write slot, using the inputs present on that edge. At no edge do both hosts write.
- R4: When a host asserts write enable (1 = write) in its window, its read output after that window equals the data it wrote to that address.
- R5: With write enable at 0, a host's read output after its window equals the word already stored at the sampled address.
- R6: The address, data and enable inputs of a host are captured at the start of its window. Values applied later in the window, or outside it, are not written and do not change the address that is read.
- R7: Each read output holds constant from one of its read slots to the next.
- R8: A write by one host is returned to the other host at that host's next read slot.
- R9: When both hosts write the same address in one round, host B's data remains, because it is written later.
- R10: Data words are 4 bits wide and there are 4 words, selected by a 2-bit address. All 16 data values are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_addr | input | 2 | Host A word address |
| a_wdata | input | 4 | Host A write data |
| a_we | input | 1 | Host A write enable (1 = write) |
| a_rdata | output | 4 | Host A registered read data |
| b_addr | input | 2 | Host B word address |
| b_wdata | input | 4 | Host B write data |
| b_we | input | 1 | Host B write enable (1 = write) |
| b_rdata | output | 4 | Host B registered read data |

## Verification
Two functions can meet in one round. The first is a write from one host with a read of the same word by the other host. The second is a write from each host to the same word, where the later slot must win. The bench sweeps every combination of A address, B address and both write enables, with data values that vary by step. It predicts each read output from a slot-ordered model: A writes, A reads, B writes, B reads. To catch a write that leaks outside its window, each host's inputs are changed to conflicting values, with write enable at 1, right after its window opens. Directed rounds then read back the words those values targeted.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    localparam int TSM_DATA_W = 4;
    localparam int TSM_ADDR_W = 2;
    localparam int TSM_HOSTS  = 2;
    localparam int TSM_SLOT_W = 2;

    typedef enum logic [TSM_SLOT_W-1:0] {
        SLOT_A_WR = 2'd0,
        SLOT_A_RD = 2'd1,
        SLOT_B_WR = 2'd2,
        SLOT_B_RD = 2'd3
    } tsm_slot_e;

    function automatic tsm_slot_e tsm_next_slot(tsm_slot_e s);
        case (s)
            SLOT_A_WR: return SLOT_A_RD;
            SLOT_A_RD: return SLOT_B_WR;
            SLOT_B_WR: return SLOT_B_RD;
            default:   return SLOT_A_WR;
        endcase
    endfunction

    function automatic logic [TSM_SLOT_W-1:0] tsm_wr_slot(int host);
        return TSM_SLOT_W'(2 * host);
    endfunction

    function automatic logic [TSM_SLOT_W-1:0] tsm_rd_slot(int host);
        return TSM_SLOT_W'(2 * host + 1);
    endfunction

endpackage

// File: rtl/tsm_slot_seq.sv
module tsm_slot_seq
    import tsm_pkg::*;
#(
    parameter int HOSTS = TSM_HOSTS
) (
    input  logic             clk,
    input  logic             rst,
    output logic [HOSTS-1:0] wr_win,
    output logic [HOSTS-1:0] rd_win
);

    tsm_slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) slot_q <= SLOT_A_WR;
        else     slot_q <= tsm_next_slot(slot_q);
    end

    for (genvar h = 0; h < HOSTS; h++) begin : g_dec
        assign wr_win[h] = (slot_q == tsm_wr_slot(h));
        assign rd_win[h] = (slot_q == tsm_rd_slot(h));
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (slot_q == TSM_SLOT_W'($past(slot_q) + 2'd1))); // R2

endmodule

// File: rtl/tsm_host_port.sv
module tsm_host_port #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_win,
    input  logic              rd_win,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata_q;

    // write request travels with the window-opening edge
    assign wr_req  = wr_win & we_i;
    assign wr_addr = addr_i;
    assign wr_data = wdata_i;

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (wr_win) addr_q <= addr_i;
    end

    assign rd_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (rd_win) rdata_q <= rd_word;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/tsm_store.sv
module tsm_store #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 4,
    parameter int HOSTS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HOSTS-1:0]  wr_en,
    input  logic [ADDR_W-1:0] wr_addr [HOSTS],
    input  logic [DATA_W-1:0] wr_data [HOSTS],
    input  logic [ADDR_W-1:0] rd_addr [HOSTS],
    output logic [DATA_W-1:0] rd_data [HOSTS]
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic              hit;
        logic [DATA_W-1:0] nxt;
        always_comb begin
            hit = 1'b0;
            nxt = mem_q[w];
            for (int h = 0; h < HOSTS; h++) begin
                if (wr_en[h] && (wr_addr[h] == ADDR_W'(w))) begin
                    hit = 1'b1;
                    nxt = wr_data[h];
                end
            end
        end
        always_ff @(posedge clk) begin
            if (rst)      mem_q[w] <= '0;
            else if (hit) mem_q[w] <= nxt;
        end
    end

    for (genvar h = 0; h < HOSTS; h++) begin : g_rd
        assign rd_data[h] = mem_q[rd_addr[h]];
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en)); // R3

endmodule

// File: rtl/tsm_shared_mem.sv
module tsm_shared_mem
    import tsm_pkg::*;
#(
    parameter int ADDR_W = TSM_ADDR_W,
    parameter int DATA_W = TSM_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_we,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_we,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int HOSTS = TSM_HOSTS;

    logic [HOSTS-1:0]  wr_win, rd_win, wr_req;
    logic [ADDR_W-1:0] h_addr  [HOSTS];
    logic [DATA_W-1:0] h_wdata [HOSTS];
    logic [HOSTS-1:0]  h_we;
    logic [DATA_W-1:0] h_rdata [HOSTS];
    logic [ADDR_W-1:0] w_addr  [HOSTS];
    logic [DATA_W-1:0] w_data  [HOSTS];
    logic [ADDR_W-1:0] r_addr  [HOSTS];
    logic [DATA_W-1:0] r_word  [HOSTS];

    assign h_addr[0]  = a_addr;
    assign h_wdata[0] = a_wdata;
    assign h_we[0]    = a_we;
    assign h_addr[1]  = b_addr;
    assign h_wdata[1] = b_wdata;
    assign h_we[1]    = b_we;
    assign a_rdata    = h_rdata[0];
    assign b_rdata    = h_rdata[1];

    tsm_slot_seq #(.HOSTS(HOSTS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .wr_win (wr_win),
        .rd_win (rd_win)
    );

    for (genvar h = 0; h < HOSTS; h++) begin : g_host
        tsm_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
            .clk     (clk),
            .rst     (rst),
            .wr_win  (wr_win[h]),
            .rd_win  (rd_win[h]),
            .addr_i  (h_addr[h]),
            .wdata_i (h_wdata[h]),
            .we_i    (h_we[h]),
            .wr_req  (wr_req[h]),
            .wr_addr (w_addr[h]),
            .wr_data (w_data[h]),
            .rd_addr (r_addr[h]),
            .rd_word (r_word[h]),
            .rdata   (h_rdata[h])
        );
    end

    tsm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOSTS(HOSTS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_req),
        .wr_addr (w_addr),
        .wr_data (w_data),
        .rd_addr (r_addr),
        .rd_data (r_word)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (a_rdata == '0) && (b_rdata == '0)); // R1

    AST_OWN_WRITE_BACK_A: assert property (@(posedge clk) disable iff (rst)
        (wr_win[0] && a_we) |-> ##2 (a_rdata == $past(a_wdata, 2))); // R4

    AST_OWN_WRITE_BACK_B: assert property (@(posedge clk) disable iff (rst)
        (wr_win[1] && b_we) |-> ##2 (b_rdata == $past(b_wdata, 2))); // R4

    AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        !$stable(a_rdata) |-> $past(rd_win[0])); // R7

    AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        !$stable(b_rdata) |-> $past(rd_win[1])); // R7

endmodule

// File: tb/tsm_shared_mem_tb.sv
`timescale 1ns/1ps
module tsm_shared_mem_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] a_addr = '0, b_addr = '0;
    logic [3:0] a_wdata = '0, b_wdata = '0;
    logic       a_we = 1'b0, b_we = 1'b0;
    logic [3:0] a_rdata, b_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] model [4];

    always #4 clk = ~clk;

    tsm_shared_mem u_dut (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_rdata(b_rdata)
    );

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One four-slot round; entered and left at a falling edge.
    task automatic round(input logic [1:0] aa, input logic [3:0] ad, input logic awe,
                         input logic [1:0] ba, input logic [3:0] bd, input logic bwe,
                         input string ta, input string tb);
        logic [3:0] a_old, a_hold, b_hold;
        a_addr = aa; a_wdata = ad; a_we = awe;
        b_addr = ba; b_wdata = bd; b_we = bwe;
        a_old  = a_rdata;
        b_hold = b_rdata;
        @(posedge clk); @(negedge clk);                // slot 0 done: A write
        if (awe) model[aa] = ad;
        check("R2", a_rdata, a_old);
        a_addr = ~aa; a_wdata = ~ad; a_we = 1'b1;      // R6 late change
        @(posedge clk); @(negedge clk);                // slot 1 done: A read
        check(ta, a_rdata, model[aa]);
        check("R7", b_rdata, b_hold);
        a_hold = a_rdata;
        @(posedge clk); @(negedge clk);                // slot 2 done: B write
        if (bwe) model[ba] = bd;
        check("R7", a_rdata, a_hold);
        b_addr = ~ba; b_wdata = ~bd; b_we = 1'b1;      // R6 late change
        @(posedge clk); @(negedge clk);                // slot 3 done: B read
        check(tb, b_rdata, model[ba]);
        check("R7", a_rdata, a_hold);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", a_rdata, 4'h0);
        check("R1", b_rdata, 4'h0);

        // R1: every word reads zero after reset
        for (int k = 0; k < 4; k++)
            round(2'(k), 4'h0, 1'b0, 2'(3 - k), 4'h0, 1'b0, "R1", "R1");

        // Sweep all address pairs and enable combinations (R4 R5 R8 R9)
        for (int i = 0; i < 64; i++) begin
            logic [1:0] aa, ba;
            logic [3:0] ad, bd;
            logic awe, bwe;
            aa = i[1:0]; ba = i[3:2]; awe = i[4]; bwe = i[5];
            ad = 4'((i * 7 + 3) & 15);
            bd = 4'((i * 5 + 11) & 15);
            round(aa, ad, awe, ba, bd, bwe,
                  awe ? "R4" : "R5",
                  bwe ? "R4" : ((awe && aa == ba) ? "R8" : "R5"));
        end

        // R8: B write seen by A at A's next read slot
        round(2'd0, 4'h0, 1'b0, 2'd2, 4'h9, 1'b1, "R5", "R4");
        round(2'd2, 4'h0, 1'b0, 2'd1, 4'h0, 1'b0, "R8", "R5");

        // R9: both write address 1; B's later data survives
        round(2'd1, 4'h6, 1'b1, 2'd1, 4'hC, 1'b1, "R4", "R4");
        round(2'd1, 4'h0, 1'b0, 2'd1, 4'h0, 1'b0, "R9", "R9");

        // R6: late A change targeted ~0 = addr 3 with ~5 = A; addr 3 untouched
        round(2'd3, 4'h3, 1'b1, 2'd0, 4'h0, 1'b0, "R4", "R5");
        round(2'd0, 4'h5, 1'b1, 2'd2, 4'h0, 1'b0, "R4", "R5");
        round(2'd3, 4'h0, 1'b0, 2'd3, 4'h0, 1'b0, "R6", "R6");
        // late B change targeted ~2 = addr 1; addr 1 keeps its value
        round(2'd1, 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, "R6", "R5");

        // R10: full data range through every word
        for (int v = 0; v < 16; v++)
            round(2'(v), 4'(v), 1'b1, 2'(v + 1), 4'(15 - v), 1'b1, "R10", "R10");
        for (int k = 0; k < 4; k++)
            round(2'(k), 4'h0, 1'b0, 2'(k), 4'h0, 1'b0, "R10", "R10");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule